// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the pixel clock and the raster timing for a parallel RGB display panel of 480 by 272 active pixels. The pixel clock is derived from the system clock through a programmable divider. Line and frame counters advance once per pixel clock, and the horizontal sync, vertical sync and data-enable outputs are decoded from them. Pixels arrive from an upstream stream through a ready/valid handshake and are driven onto a 24-bit output bus. In the narrow mode each colour keeps only its top six bits on an 18-bit bus.

The active window is positioned by delays counted from the start of each sync pulse, not by separate porches. The horizontal window opens a fixed number of pixel clocks after hsync rises. The vertical window opens a fixed number of lines after vsync rises. The vsync pulse lasts a whole number of line periods. Every output changes in the system clock cycle in which the pixel clock falls, so a panel that samples on the rising edge sees stable data. Geometry is set by parameters. The defaults are 525 clocks per line, a 41-clock hsync, a 43-clock horizontal delay, 286 lines per frame, a 10-line vsync and a 12-line vertical delay.

Top module: `lcd_tgen_top`

## Requirements
- R1: `lcdPclk` has a period of 2*(pixDiv+1) system clocks and stays high for pixDiv+1 of them.
- R2: `lcdHsync`, `lcdVsync`, `lcdDe` and `lcdRgb` change only in the system clock cycle in which `lcdPclk` goes from high to low.
- R3: A line lasts LINE_LEN pixel clocks, numbered from column 0. `lcdHsync` (active high) is high for columns 0 to HS_W-1 and low for the rest of the line.
- R4: Within an active line, `lcdDe` is high for columns HDELAY to HDELAY+ACT_PIX-1 and low for all other columns.
- R5: A frame lasts FRAME_LINES lines, numbered from line 0. `lcdVsync` (active high) is high for lines 0 to VS_W-1, which is VS_W*LINE_LEN pixel clocks.
- R6: Only lines VDELAY to VDELAY+ACT_LINES-1 are active. On every other line `lcdDe` stays low.
- R7: `pixReady` is high for exactly one system clock before each pixel clock whose position is inside the active window, and at no other time. Each such pulse consumes one pixel.
- R8: With `rgb666Mode` low, `lcdRgb` during an active position equals the 24-bit `pixData` word ({red[7:0], green[7:0], blue[7:0]}) that was presented when `pixReady` was high.
- R9: With `rgb666Mode` high, `lcdRgb` during an active position equals {6'b0, red[7:2], green[7:2], blue[7:2]} of the consumed word.
- R10: `lcdRgb` is zero outside the active window. It is also zero at an active position whose pixel was not valid when consumed. In that case `lcdDe` remains high and the timing is unchanged.
- R11: During and right after reset, `lcdPclk` is low, both syncs are high, `lcdDe` is low and `lcdRgb` is zero. The first pixel clock after reset shows line 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixDiv | input | 16 | Pixel clock divider value |
| rgb666Mode | input | 1 | 1 selects 18-bit truncated output, 0 selects full 24-bit output |
| pixData | input | 24 | Upstream pixel {red, green, blue} |
| pixValid | input | 1 | Upstream pixel is valid |
| pixReady | output | 1 | Pixel consumed this cycle |
| lcdPclk | output | 1 | Pixel clock to the panel |
| lcdHsync | output | 1 | Horizontal sync, active high |
| lcdVsync | output | 1 | Vertical sync, active high |
| lcdDe | output | 1 | Active data window |
| lcdRgb | output | 24 | Pixel output bus |

## Verification
The hardest case to reach is a pixel clock in which a valid window position is paired with an invalid pixel. Timing must continue unchanged while the bus shows zero. It is also hard to confirm that nothing moves between pixel clock falls when the divider is large. The bench shrinks the raster geometry through parameters so that several whole frames fit in a short run. It toggles `pixValid` pseudo-randomly and runs the divider at 0, 1 and 3. A reference position counter, advanced on every observed pixel clock fall, judges each output against the window rules.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

  // Strobes passed from timing control to the pixel datapath.
  typedef struct packed {
    logic step;     // pixel clock falls at this edge
    logic hsNext;   // hsync level for the position being entered
    logic vsNext;   // vsync level for the position being entered
    logic actNext;  // position being entered lies in the active window
  } tgenStrobe_t;

endpackage

// File: rtl/lcd_tgen_ctrl.sv
module lcd_tgen_ctrl
  import lcd_tgen_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int LINE_LEN    = 525,
  parameter int ACT_PIX     = 480,
  parameter int HS_W        = 41,
  parameter int HDELAY      = 43,
  parameter int FRAME_LINES = 286,
  parameter int ACT_LINES   = 272,
  parameter int VS_W        = 10,
  parameter int VDELAY      = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] pixDiv,
  output logic             pclk,
  output tgenStrobe_t      strb
);

  localparam int HW = $clog2(LINE_LEN);
  localparam int VW = $clog2(FRAME_LINES);
  localparam logic [HW-1:0] H_LAST   = HW'(LINE_LEN - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(FRAME_LINES - 1);
  localparam logic [HW-1:0] H_ACT_LO = HW'(HDELAY);
  localparam logic [HW-1:0] H_ACT_HI = HW'(HDELAY + ACT_PIX);
  localparam logic [VW-1:0] V_ACT_LO = VW'(VDELAY);
  localparam logic [VW-1:0] V_ACT_HI = VW'(VDELAY + ACT_LINES);
  localparam logic [HW-1:0] H_SYNC   = HW'(HS_W);
  localparam logic [VW-1:0] V_SYNC   = VW'(VS_W);

  logic [DIV_W-1:0] divCnt;
  logic             halfDone;
  logic [HW-1:0]    hCnt, hNext;
  logic [VW-1:0]    vCnt, vNext;

  // A half period ends once the divider count reaches the programmed value.
  assign halfDone = (divCnt >= pixDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      pclk   <= 1'b0;
    end else if (halfDone) begin
      divCnt <= '0;
      pclk   <= ~pclk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Next raster position, entered when the pixel clock falls.
  always_comb begin
    hNext = hCnt + 1'b1;
    vNext = vCnt;
    if (hCnt == H_LAST) begin
      hNext = '0;
      vNext = (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.step) begin
      hCnt <= hNext;
      vCnt <= vNext;
    end
  end

  assign strb.step    = pclk && halfDone;
  assign strb.hsNext  = (hNext < H_SYNC);
  assign strb.vsNext  = (vNext < V_SYNC);
  assign strb.actNext = (hNext >= H_ACT_LO) && (hNext < H_ACT_HI) &&
                        (vNext >= V_ACT_LO) && (vNext < V_ACT_HI);

endmodule

// File: rtl/lcd_tgen_dp.sv
module lcd_tgen_dp
  import lcd_tgen_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int TRUNC_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  tgenStrobe_t         strb,
  input  logic                rgb666Mode,
  input  logic [3*CH_W-1:0]   pixData,
  input  logic                pixValid,
  output logic                pixReady,
  output logic                hsync,
  output logic                vsync,
  output logic                de,
  output logic [3*CH_W-1:0]   rgb
);

  localparam int PIX_W = 3 * CH_W;
  localparam int NAR_W = 3 * TRUNC_W;

  logic [PIX_W-1:0] fmt666;

  // Keep the upper TRUNC_W bits of each colour, packed at the bottom of the bus.
  generate
    for (genvar c = 0; c < 3; c++) begin : g_ch
      assign fmt666[c*TRUNC_W +: TRUNC_W] = pixData[c*CH_W + (CH_W - TRUNC_W) +: TRUNC_W];
    end
  endgenerate
  assign fmt666[PIX_W-1:NAR_W] = '0;

  assign pixReady = strb.step && strb.actNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsync <= 1'b1;
      vsync <= 1'b1;
      de    <= 1'b0;
      rgb   <= '0;
    end else if (strb.step) begin
      hsync <= strb.hsNext;
      vsync <= strb.vsNext;
      de    <= strb.actNext;
      if (strb.actNext && pixValid)
        rgb <= rgb666Mode ? fmt666 : pixData;
      else
        rgb <= '0;
    end
  end

endmodule

// File: rtl/lcd_tgen_top.sv
module lcd_tgen_top
  import lcd_tgen_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int CH_W        = 8,
  parameter int TRUNC_W     = 6,
  parameter int LINE_LEN    = 525,
  parameter int ACT_PIX     = 480,
  parameter int HS_W        = 41,
  parameter int HDELAY      = 43,
  parameter int FRAME_LINES = 286,
  parameter int ACT_LINES   = 272,
  parameter int VS_W        = 10,
  parameter int VDELAY      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  pixDiv,
  input  logic              rgb666Mode,
  input  logic [3*CH_W-1:0] pixData,
  input  logic              pixValid,
  output logic              pixReady,
  output logic              lcdPclk,
  output logic              lcdHsync,
  output logic              lcdVsync,
  output logic              lcdDe,
  output logic [3*CH_W-1:0] lcdRgb
);

  tgenStrobe_t strb;

  lcd_tgen_ctrl #(
    .DIV_W(DIV_W), .LINE_LEN(LINE_LEN), .ACT_PIX(ACT_PIX), .HS_W(HS_W),
    .HDELAY(HDELAY), .FRAME_LINES(FRAME_LINES), .ACT_LINES(ACT_LINES),
    .VS_W(VS_W), .VDELAY(VDELAY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pixDiv(pixDiv), .pclk(lcdPclk), .strb(strb)
  );

  lcd_tgen_dp #(.CH_W(CH_W), .TRUNC_W(TRUNC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rgb666Mode(rgb666Mode),
    .pixData(pixData), .pixValid(pixValid), .pixReady(pixReady),
    .hsync(lcdHsync), .vsync(lcdVsync), .de(lcdDe), .rgb(lcdRgb)
  );

endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
  parameter int PIX_W   = 24,
  parameter int NAR_W   = 18,
  parameter int HS_W    = 41,
  parameter int HDELAY  = 43
) (
  input logic             clk,
  input logic             rstN,
  input logic             pclk,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [PIX_W-1:0] rgb,
  input logic             pixReady,
  input logic             rgb666Mode
);

  AST_OUT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (pclk || !$past(pclk)) |-> ($stable(hsync) && $stable(vsync) && $stable(de) && $stable(rgb))); // R2

  AST_READY_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |=> de); // R7

  AST_READY_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |-> pclk); // R7

  AST_RGB_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    !de |-> (rgb == '0)); // R10

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pixReady && rgb666Mode) |=> (rgb[PIX_W-1:NAR_W] == '0)); // R9

  AST_NO_DE_IN_HSYNC: assert property (@(posedge clk) disable iff (!rstN)
    ((HDELAY >= HS_W) && hsync) |-> !de); // R4

endmodule

bind lcd_tgen_top lcd_tgen_chk #(
  .PIX_W(3*CH_W), .NAR_W(3*TRUNC_W), .HS_W(HS_W), .HDELAY(HDELAY)
) u_chk (
  .clk(clk), .rstN(rstN), .pclk(lcdPclk), .hsync(lcdHsync), .vsync(lcdVsync),
  .de(lcdDe), .rgb(lcdRgb), .pixReady(pixReady), .rgb666Mode(rgb666Mode)
);

// File: tb/tb_lcd_tgen_top.sv
module tb_lcd_tgen_top;

  localparam int LINE_LEN    = 20;
  localparam int ACT_PIX     = 8;
  localparam int HS_W        = 3;
  localparam int HDELAY      = 5;
  localparam int FRAME_LINES = 10;
  localparam int ACT_LINES   = 4;
  localparam int VS_W        = 2;
  localparam int VDELAY      = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pixDiv = '0;
  logic        rgb666Mode = 1'b0;
  logic [23:0] pixData = 24'h5A3C1F;
  logic        pixValid = 1'b1;
  logic        pixReady, lcdPclk, lcdHsync, lcdVsync, lcdDe;
  logic [23:0] lcdRgb;
  logic        validMode = 1'b0;

  int errCnt = 0;
  int chkCnt = 0;

  always #4 clk = ~clk;

  lcd_tgen_top #(
    .LINE_LEN(LINE_LEN), .ACT_PIX(ACT_PIX), .HS_W(HS_W), .HDELAY(HDELAY),
    .FRAME_LINES(FRAME_LINES), .ACT_LINES(ACT_LINES), .VS_W(VS_W), .VDELAY(VDELAY)
  ) dut (
    .clk(clk), .rstN(rstN), .pixDiv(pixDiv), .rgb666Mode(rgb666Mode),
    .pixData(pixData), .pixValid(pixValid), .pixReady(pixReady),
    .lcdPclk(lcdPclk), .lcdHsync(lcdHsync), .lcdVsync(lcdVsync),
    .lcdDe(lcdDe), .lcdRgb(lcdRgb)
  );

  // Upstream pixel source: new pseudo-random word shortly after every edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      pixValid <= validMode ? pixData[5] : 1'b1;
      pixData  <= {pixData[22:0], pixData[23] ^ pixData[22] ^ pixData[21] ^ pixData[16]};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] fmtPix(input logic [23:0] d, input bit narrow);
    return narrow ? {6'b0, d[23:18], d[15:10], d[7:2]} : d;
  endfunction

  // One scenario: reset with the given settings, then follow the raster.
  task automatic run_scn(input int div, input bit narrow, input bit vmode, input int pclks);
    int h = 0, v = 0, falls = 0, sinceFall = 0, highCnt = 0;
    bit prevP, rdyPend, expHs, expVs, expAct;
    logic [23:0] latched, expRgb;
    logic [26:0] prevOut;
    rstN = 1'b0;
    pixDiv = 16'(div);
    rgb666Mode = narrow;
    validMode = vmode;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R11: reset state, position line 0 column 0 shown first
    chk(lcdPclk == 1'b0, "R11 pclk", 32'(lcdPclk), 0);
    chk(lcdHsync == 1'b1, "R11 hsync", 32'(lcdHsync), 1);
    chk(lcdVsync == 1'b1, "R11 vsync", 32'(lcdVsync), 1);
    chk(lcdDe == 1'b0, "R11 de", 32'(lcdDe), 0);
    chk(lcdRgb == '0, "R11 rgb", 32'(lcdRgb), 0);
    prevP = 1'b0;
    rdyPend = 1'b0;
    latched = '0;
    prevOut = {lcdHsync, lcdVsync, lcdDe, lcdRgb};
    while (falls < pclks) begin
      if (pixReady) begin
        chk(!rdyPend, "R7 single ready per pixel clock", 1, 0);
        rdyPend = 1'b1;
        latched = pixValid ? fmtPix(pixData, narrow) : 24'h0;
      end
      if (prevP && !lcdPclk) begin
        falls++;
        if (falls > 1) begin
          chk(sinceFall == 2*(div+1), "R1 period", 32'(sinceFall), 32'(2*(div+1)));
          chk(highCnt == div+1, "R1 high time", 32'(highCnt), 32'(div+1));
        end
        h++;
        if (h == LINE_LEN) begin
          h = 0;
          v = (v == FRAME_LINES-1) ? 0 : v + 1;
        end
        expHs  = (h < HS_W);
        expVs  = (v < VS_W);
        expAct = (h >= HDELAY) && (h < HDELAY+ACT_PIX) && (v >= VDELAY) && (v < VDELAY+ACT_LINES);
        expRgb = expAct ? latched : 24'h0;
        chk(lcdHsync == expHs, "R3 hsync", 32'(lcdHsync), 32'(expHs));
        chk(lcdVsync == expVs, "R5 vsync", 32'(lcdVsync), 32'(expVs));
        if (v >= VDELAY && v < VDELAY+ACT_LINES)
          chk(lcdDe == expAct, "R4 de columns", 32'(lcdDe), 32'(expAct));
        else
          chk(lcdDe == expAct, "R6 de lines", 32'(lcdDe), 32'(expAct));
        chk(rdyPend == expAct, "R7 ready", 32'(rdyPend), 32'(expAct));
        if (!expAct || !pixValid && latched == 0)
          chk(lcdRgb == expRgb, "R10 rgb zero", 32'(lcdRgb), 32'(expRgb));
        else if (narrow)
          chk(lcdRgb == expRgb, "R9 rgb narrow", 32'(lcdRgb), 32'(expRgb));
        else
          chk(lcdRgb == expRgb, "R8 rgb full", 32'(lcdRgb), 32'(expRgb));
        rdyPend = 1'b0;
        sinceFall = 0;
        highCnt = 0;
      end else begin
        chk({lcdHsync, lcdVsync, lcdDe, lcdRgb} == prevOut, "R2 stable between falls",
            32'({lcdHsync, lcdVsync, lcdDe, lcdRgb}), 32'(prevOut));
      end
      prevOut = {lcdHsync, lcdVsync, lcdDe, lcdRgb};
      prevP = lcdPclk;
      if (lcdPclk) highCnt++;
      sinceFall++;
      @(negedge clk);
    end
  endtask

  task automatic t_full_colour();
    run_scn(0, 1'b0, 1'b0, 2*LINE_LEN*FRAME_LINES + 50);
  endtask

  task automatic t_narrow_slow();
    run_scn(3, 1'b1, 1'b0, LINE_LEN*FRAME_LINES + 50);
  endtask

  task automatic t_underflow();
    run_scn(1, 1'b0, 1'b1, LINE_LEN*FRAME_LINES + 50);
  endtask

  task automatic t_narrow_underflow();
    run_scn(0, 1'b1, 1'b1, LINE_LEN*FRAME_LINES + 20);
  endtask

  initial begin
    #(8 * 150000);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    t_full_colour();
    t_narrow_slow();
    t_underflow();
    t_narrow_underflow();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule